// File: doc/BRIEF.md
# Frame Receive Word Buffer with DMA Request

This block collects the payload bytes of frames that arrive from a single-wire line receiver and hands them to a DMA controller as 32-bit words. Bytes are packed into a word assembler. Each finished word moves into a one-word read-data register. A "data ready" flag is raised at that point, and the same flag drives the DMA request line. The DMA controller reads the word through the register bus, and that read takes the flag down again.

When the receiver signals the end of a frame, any partly filled last word is flushed with zero padding. The block then raises a "buffer full" flag, which can interrupt the CPU, and captures the payload byte count in a length register. Software handles the frame once: it reads the length, processes the buffer in memory, and writes one to a clear bit to re-arm reception. Bytes that arrive while the buffer-full flag is still set are refused and recorded in an overrun flag.

The receiver side is a byte stream with valid, end-of-frame and error strobes. The software side is a single-cycle register bus with combinational read data.

Top module: `frx_dma_buffer`

## Requirements
- R1: Payload bytes are packed little-endian: the first byte of each group of four lands in bits 7:0 of the read-data word (offset 0x10). The data-ready flag (status offset 0x4, bit 0) is high from the edge that accepts the fourth byte.
- R2: Reception runs only when control bit 0 (DMA enable, offset 0x0) is 1 and control bit 1 (alternate receive mode) is 0. Otherwise, incoming bytes, end-of-frame and error strobes change no status, no length and no request.
- R3: `dma_req` is high exactly while the data-ready flag is set and reception is enabled as in R2.
- R4: A read of offset 0x10 clears the data-ready flag at that edge, unless a new word is completed in the same cycle.
- R5: An end-of-frame strobe sets the buffer-full flag (status bit 1). A partly filled last word is delivered with its unused upper bytes at zero.
- R6: The frame length register (offset 0x14) holds the payload byte count of the last completed frame.
- R7: A write to offset 0x8 with bit 1 set clears the buffer-full flag. A write with bit 2 set clears the overrun flag (status bit 2).
- R8: `irq` is high exactly while the buffer-full flag is set and interrupt-enable bit 1 (offset 0xC) is 1.
- R9: A frame holds at most 32 payload bytes. Further bytes are dropped, set the overrun flag, and leave the length at 32.
- R10: While the buffer-full flag is set, incoming bytes are dropped, the overrun flag is set, and the frame length register keeps its value.
- R11: An error strobe discards the frame in progress. Its partial word is lost, the buffer-full flag is not set, and the next byte starts a new frame.
- R12: A word completed while the data-ready flag is still set, with no read in that cycle, is discarded. The held word stays readable and the overrun flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received payload byte |
| rx_valid | input | 1 | rx_data carries a byte this cycle |
| rx_eof | input | 1 | End of frame; a byte valid in the same cycle is the last one |
| rx_err | input | 1 | Frame error, abort current frame |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| dma_req | output | 1 | DMA request, a word is waiting |
| irq | output | 1 | Buffer-full interrupt |

## Verification
Assertions check the following on every cycle:
- the byte counter never passes the frame limit;
- an error strobe empties the assembler;
- a read without a new word empties the read-data register;
- a refused word leaves the held word untouched;
- end of frame always raises buffer-full, and the clear bit always drops it;
- the length stays fixed while buffer-full is set;
- a disabled receiver leaves flags and length alone.

Only the bench scenarios can show the following:
- the byte order and zero padding of delivered words, compared against a scoreboard of expected words while a modelled DMA agent drains the register;
- the truncation of long frames;
- the discarding of aborted frames;
- the interplay of request gating, the interrupt enable and the overrun paths.

// File: rtl/frx_pkg.sv
package frx_pkg;
   localparam int unsigned REG_AW = 5;

   localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h00;
   localparam logic [REG_AW-1:0] OFF_STAT  = 5'h04;
   localparam logic [REG_AW-1:0] OFF_CLR   = 5'h08;
   localparam logic [REG_AW-1:0] OFF_IEN   = 5'h0C;
   localparam logic [REG_AW-1:0] OFF_RDATA = 5'h10;
   localparam logic [REG_AW-1:0] OFF_FLEN  = 5'h14;

   localparam int unsigned CTRL_DMA_EN  = 0;
   localparam int unsigned CTRL_ALT_RX  = 1;
   localparam int unsigned STAT_READY   = 0;
   localparam int unsigned STAT_FULL    = 1;
   localparam int unsigned STAT_OVR     = 2;

   typedef struct packed {
      logic ovr;
      logic full;
      logic ready;
   } frx_stat_t;
endpackage

// File: rtl/frx_packer.sv
module frx_packer #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned MAX_BYTES = 32,
   localparam int unsigned LANES  = WORD_W / 8,
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned CNT_W  = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        byte_i,
   input  logic              valid_i,
   input  logic              eof_i,
   input  logic              err_i,
   output logic              push_o,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  len_o,
   output logic              ovf_o
);
   generate
      if (WORD_W % 8 != 0 || LANES < 2) begin : g_bad_width
         $error("frx_packer: WORD_W must be a multiple of 8 and at least 16");
      end
      if (MAX_BYTES % LANES != 0 || MAX_BYTES == 0) begin : g_bad_max
         $error("frx_packer: MAX_BYTES must be a nonzero multiple of the lane count");
      end
   endgenerate

   logic [LANE_W-1:0] lane_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] merged;
   logic              byte_ok, last_lane, full_push, has_bytes;

   assign byte_ok   = valid_i && (cnt_q < CNT_W'(MAX_BYTES));
   assign last_lane = (lane_q == LANE_W'(LANES - 1));
   assign full_push = byte_ok && last_lane;
   assign has_bytes = byte_ok || (lane_q != '0);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*8 +: 8] = (byte_ok && lane_q == LANE_W'(l)) ? byte_i : acc_q[l*8 +: 8];
   end

   assign push_o = !err_i && (full_push || (eof_i && has_bytes));
   assign word_o = merged;
   assign done_o = eof_i && !err_i;
   assign len_o  = cnt_q + CNT_W'(byte_ok);
   assign ovf_o  = valid_i && !byte_ok && !err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_q <= '0;
         cnt_q  <= '0;
         acc_q  <= '0;
      end else if (err_i || eof_i) begin
         lane_q <= '0;
         cnt_q  <= '0;
         acc_q  <= '0;
      end else if (byte_ok) begin
         cnt_q <= cnt_q + 1'b1;
         if (last_lane) begin
            lane_q <= '0;
            acc_q  <= '0;
         end else begin
            lane_q <= lane_q + 1'b1;
            acc_q  <= merged;
         end
      end
   end

   // R9: the frame byte counter never passes the frame limit
   a_r9_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_BYTES));

   // R11: an error strobe leaves the assembler empty
   a_r11_err_flush: assert property (@(posedge clk) disable iff (!rst_n)
      err_i |=> (cnt_q == '0 && lane_q == '0 && acc_q == '0));
endmodule

// File: rtl/frx_rdbuf.sv
module frx_rdbuf #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              pop_i,
   output logic              ready_o,
   output logic [WORD_W-1:0] data_o,
   output logic              lost_o
);
   logic              ready_q;
   logic [WORD_W-1:0] data_q;

   assign ready_o = ready_q;
   assign data_o  = data_q;
   assign lost_o  = push_i && ready_q && !pop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         data_q  <= '0;
      end else if (push_i && (!ready_q || pop_i)) begin
         ready_q <= 1'b1;
         data_q  <= word_i;
      end else if (pop_i) begin
         ready_q <= 1'b0;
      end
   end

   // R4: a read with no arriving word empties the register
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> !ready_q);

   // R12: a refused word does not disturb the held one
   a_r12_keep_held: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && ready_q && !pop_i) |=> (ready_q && $stable(data_q)));
endmodule

// File: rtl/frx_flags.sv
module frx_flags #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             ovr_evt_i,
   input  logic             clr_full_i,
   input  logic             clr_ovr_i,
   input  logic             ien_i,
   output logic             full_o,
   output logic             ovr_o,
   output logic [CNT_W-1:0] len_o,
   output logic             irq_o
);
   logic             full_q, ovr_q;
   logic [CNT_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
         len_q  <= '0;
      end else begin
         if (done_i) begin
            full_q <= 1'b1;
            len_q  <= len_i;
         end else if (clr_full_i) begin
            full_q <= 1'b0;
         end
         if (ovr_evt_i)      ovr_q <= 1'b1;
         else if (clr_ovr_i) ovr_q <= 1'b0;
      end
   end

   assign full_o = full_q;
   assign ovr_o  = ovr_q;
   assign len_o  = len_q;
   assign irq_o  = full_q && ien_i;

   // R5: end of frame always raises buffer-full
   a_r5_eof_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> full_q);

   // R7: the clear bit drops buffer-full when no frame ends at the same time
   a_r7_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_full_i && !done_i) |=> !full_q);

   // R10: the length is frozen while buffer-full is set
   a_r10_len_held: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |=> $stable(len_q));
endmodule

// File: rtl/frx_dma_buffer.sv
module frx_dma_buffer #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned MAX_WORDS = 8,
   localparam int unsigned LANES     = WORD_W / 8,
   localparam int unsigned MAX_BYTES = MAX_WORDS * LANES,
   localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [7:0]                rx_data,
   input  logic                      rx_valid,
   input  logic                      rx_eof,
   input  logic                      rx_err,
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic [frx_pkg::REG_AW-1:0] bus_addr,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   output logic                      dma_req,
   output logic                      irq
);
   import frx_pkg::*;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("frx_dma_buffer: the register bus carries 32-bit words");
      end
      if (CNT_W > 32) begin : g_bad_cnt
         $error("frx_dma_buffer: frame length does not fit the register");
      end
   endgenerate

   logic [1:0]        ctrl_q;
   logic              ien_q;
   logic              rx_on, gate;
   logic              wr_ctrl, wr_clr, wr_ien, rd_word;
   logic              push, done, ovf, lost, drop;
   logic [WORD_W-1:0] word, held;
   logic [CNT_W-1:0]  len_now, len_reg;
   frx_stat_t         stat;

   assign rx_on = ctrl_q[CTRL_DMA_EN] && !ctrl_q[CTRL_ALT_RX];
   assign gate  = rx_on && !stat.full;
   assign drop  = rx_on && stat.full && rx_valid;

   assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
   assign wr_clr  = bus_sel && bus_wr && (bus_addr == OFF_CLR);
   assign wr_ien  = bus_sel && bus_wr && (bus_addr == OFF_IEN);
   assign rd_word = bus_sel && !bus_wr && (bus_addr == OFF_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ien_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
         if (wr_ien)  ien_q  <= bus_wdata[STAT_FULL];
      end
   end

   frx_packer #(.WORD_W(WORD_W), .MAX_BYTES(MAX_BYTES)) i_packer (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_i  (rx_data),
      .valid_i (rx_valid && gate),
      .eof_i   (rx_eof && gate),
      .err_i   (rx_err && gate),
      .push_o  (push),
      .word_o  (word),
      .done_o  (done),
      .len_o   (len_now),
      .ovf_o   (ovf)
   );

   frx_rdbuf #(.WORD_W(WORD_W)) i_rdbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .word_i  (word),
      .pop_i   (rd_word),
      .ready_o (stat.ready),
      .data_o  (held),
      .lost_o  (lost)
   );

   frx_flags #(.CNT_W(CNT_W)) i_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (done),
      .len_i      (len_now),
      .ovr_evt_i  (ovf || lost || drop),
      .clr_full_i (wr_clr && bus_wdata[STAT_FULL]),
      .clr_ovr_i  (wr_clr && bus_wdata[STAT_OVR]),
      .ien_i      (ien_q),
      .full_o     (stat.full),
      .ovr_o      (stat.ovr),
      .len_o      (len_reg),
      .irq_o      (irq)
   );

   assign dma_req = stat.ready && rx_on;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFF_CTRL:  bus_rdata[1:0] = ctrl_q;
         OFF_STAT:  bus_rdata[2:0] = stat;
         OFF_IEN:   bus_rdata[STAT_FULL] = ien_q;
         OFF_RDATA: bus_rdata = held;
         OFF_FLEN:  bus_rdata[CNT_W-1:0] = len_reg;
         default:   bus_rdata = '0;
      endcase
   end

   // R2: a disabled receiver changes neither buffer-full nor the length
   a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_on && !wr_clr) |=> ($stable(stat.full) && $stable(len_reg)));
endmodule

// File: tb/test_frx_dma_buffer.sv
module test_frx_dma_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
   logic        h_sel = 1'b0, h_wr = 1'b0, m_sel = 1'b0;
   logic [4:0]  h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic        bus_sel, bus_wr;
   logic [4:0]  bus_addr;
   logic [31:0] bus_rdata;
   logic        dma_req, irq;

   int tests = 0, fails = 0;
   bit dma_on = 1'b0;
   logic [31:0] exp_q[$];

   always #2 clk = ~clk;

   assign bus_sel  = h_sel || m_sel;
   assign bus_wr   = m_sel ? 1'b0 : h_wr;
   assign bus_addr = m_sel ? 5'h10 : h_addr;

   frx_dma_buffer i_frx_dma_buffer (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_eof(rx_eof), .rx_err(rx_err), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(h_wdata), .bus_rdata(bus_rdata),
      .dma_req(dma_req), .irq(irq));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: models the DMA controller and compares against the scoreboard
   initial forever begin
      @(negedge clk);
      if (dma_on && dma_req) begin
         m_sel = 1'b1;
         #1;
         if (exp_q.size() == 0) check(bus_rdata, 32'hxxxxxxxx, "R1 unexpected word");
         else check(bus_rdata, exp_q.pop_front(), "R1 word order");
         @(negedge clk);
         m_sel = 1'b0;
      end
   end

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      h_sel = 1'b1; h_wr = 1'b1; h_addr = a; h_wdata = d;
      @(negedge clk);
      h_sel = 1'b0; h_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      h_sel = 1'b1; h_wr = 1'b0; h_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      h_sel = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'(seed * 16 + i * 3 + 1);
   endfunction

   // driver: sends a frame and pushes the words a correct design must deliver
   task automatic send_frame(input int n, input int seed, input bit eof, input bit expect_words);
      logic [31:0] w = '0;
      int k = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_data = pat(seed, i); rx_valid = 1'b1;
         rx_eof = eof && (i == n - 1);
         if (i < 32) begin
            w[k*8 +: 8] = pat(seed, i);
            k++;
            if (k == 4) begin
               if (expect_words) exp_q.push_back(w);
               w = '0; k = 0;
            end
         end
      end
      if (eof && k != 0 && expect_words) exp_q.push_back(w);
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      while ((exp_q.size() != 0 || dma_req || m_sel) && t < 300) begin
         @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
      check(32'(exp_q.size()), 32'd0, "R1 scoreboard drained");
   endtask

   logic [31:0] r;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      reg_rd(5'h04, r); check(r, 32'h0, "reset status");
      reg_rd(5'h14, r); check(r, 32'h0, "reset length");
      check({31'b0, dma_req}, 32'd0, "reset dma_req");
      check({31'b0, irq}, 32'd0, "reset irq");

      reg_wr(5'h00, 32'h1);
      reg_wr(5'h0C, 32'h2);
      dma_on = 1'b1;

      // R1 R5 R6 R8: two full words
      send_frame(8, 1, 1'b1, 1'b1);
      wait_idle();
      reg_rd(5'h04, r); check(r, 32'h2, "R5 buffer full after eof");
      reg_rd(5'h14, r); check(r, 32'd8, "R6 length 8");
      check({31'b0, irq}, 32'd1, "R8 irq with enable");
      reg_wr(5'h08, 32'h2);
      reg_rd(5'h04, r); check(r, 32'h0, "R7 full cleared");
      check({31'b0, irq}, 32'd0, "R8 irq drops after clear");

      // R5 zero padding
      send_frame(5, 2, 1'b1, 1'b1);
      wait_idle();
      reg_rd(5'h14, r); check(r, 32'd5, "R6 length 5");

      // R10: bytes while full are refused
      send_frame(4, 3, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      check({31'b0, dma_req}, 32'd0, "R10 no request while full");
      reg_rd(5'h04, r); check(r, 32'h6, "R10 overrun set");
      reg_rd(5'h14, r); check(r, 32'd5, "R10 length held");
      reg_wr(5'h08, 32'h4);
      reg_rd(5'h04, r); check(r, 32'h2, "R7 overrun cleared alone");
      reg_wr(5'h08, 32'h2);

      // R8: enable off
      reg_wr(5'h0C, 32'h0);
      send_frame(4, 4, 1'b1, 1'b1);
      wait_idle();
      check({31'b0, irq}, 32'd0, "R8 irq masked");
      reg_rd(5'h04, r); check(r, 32'h2, "R8 full still set");
      reg_wr(5'h08, 32'h2);
      reg_wr(5'h0C, 32'h2);

      // R2: alternate mode ignores traffic
      reg_wr(5'h00, 32'h3);
      send_frame(4, 5, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      check({31'b0, dma_req}, 32'd0, "R2 no request in other mode");
      reg_rd(5'h04, r); check(r, 32'h0, "R2 status untouched");
      reg_rd(5'h14, r); check(r, 32'd4, "R2 length untouched");
      reg_wr(5'h00, 32'h1);

      // R11: error aborts frame, next frame counts from zero
      send_frame(6, 6, 1'b0, 1'b1);
      @(negedge clk); rx_err = 1'b1;
      @(negedge clk); rx_err = 1'b0;
      wait_idle();
      reg_rd(5'h04, r); check(r, 32'h0, "R11 no buffer full on error");
      send_frame(3, 7, 1'b1, 1'b1);
      wait_idle();
      reg_rd(5'h14, r); check(r, 32'd3, "R11 length restarts");
      reg_wr(5'h08, 32'h2);

      // R9: oversize frame
      send_frame(36, 8, 1'b1, 1'b1);
      wait_idle();
      reg_rd(5'h14, r); check(r, 32'd32, "R9 length capped");
      reg_rd(5'h04, r); check(r, 32'h6, "R9 overrun on excess");
      reg_wr(5'h08, 32'h6);

      // R12 R3 R4: DMA stalled
      dma_on = 1'b0;
      send_frame(8, 9, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      reg_rd(5'h04, r); check(r, 32'h7, "R12 overrun on refused word");
      check({31'b0, dma_req}, 32'd1, "R3 request with data");
      reg_wr(5'h00, 32'h3);
      check({31'b0, dma_req}, 32'd0, "R3 request gated by mode");
      reg_wr(5'h00, 32'h1);
      reg_rd(5'h10, r);
      check(r, {pat(9, 3), pat(9, 2), pat(9, 1), pat(9, 0)}, "R12 first word kept");
      reg_rd(5'h04, r); check(r, 32'h6, "R4 read clears ready");
      check({31'b0, dma_req}, 32'd0, "R4 request gone");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule